// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-side register front end of a three-channel interval timer. It sits between a byte-wide processor bus and the three down-counting channel engines. It decodes an active-low chip select, active-low read and write strobes and a two-bit address. Each bus access either reaches one channel's count path or the shared control-word port. Each channel keeps its own mode, number format and byte-access code. Count bytes from the host are assembled into a 16-bit load value in the order that the access code sets. The channel engine receives a strobe when the first byte of a pair arrives and another when the load value is complete.

Reads return bytes of the live count that the channel engine supplies. After a latch command they return a frozen copy instead, taken when the command was written. A latch command travels in a control-word write with a zero access code and leaves the channel's settings alone. A single system clock is used. Every bus strobe is taken as lasting exactly one clock cycle. All outputs are registered.

Top module: `timer_bus_ctrl`

## Requirements
- R1: An access is taken only when `cs_n` is low and exactly one of `rd_n`/`wr_n` is low. Address 0, 1 and 2 reach channels 0, 1 and 2. Address 3 reaches the control-word port. With `cs_n` high, with both strobes high, or with both strobes low, no state or output changes.
- R2: A read at address 3, or any read with `cs_n` high, leaves `rdata_oe` low. The control word cannot be read back.
- R3: A control-word write uses bits [7:6] to pick the channel, and the value 3 there is ignored. Bits [5:4] are the access code. Bits [3:1] are stored and driven on that channel's `mode_o` field. Bit 0 is stored and driven on `bcd_o`: 1 means decimal and 0 means binary.
- R4: A control-word write with a nonzero access code sets the two byte pointers of the chosen channel back to the low byte. It also discards that channel's pending latched value. Other channels are not changed.
- R5: With access code 01, a count write loads `{byte, 8'h00}` and raises `load_pulse_o`. A read returns the high byte.
- R6: With access code 10, a count write loads `{8'h00, byte}` and raises `load_pulse_o`. A read returns the low byte.
- R7: With access code 11, count writes alternate between two steps. The first write fills the low byte and raises `first_pulse_o`. The second fills the high byte and raises `load_pulse_o`. Reads likewise alternate, low byte first and then high byte.
- R8: A control-word write with access code 00 is a latch command. It copies the channel's live count into a hold register and raises `latch_req_o` for that channel. Mode, number format and access code stay as they were. While a held value is pending, further latch commands to that channel are ignored.
- R9: While a held value is pending, reads return it and not the live count. The hold is released by the read that completes the programmed byte sequence. After that, reads follow the live count again.
- R10: Before a channel has received a nonzero access code, count writes to it are ignored. Reads from it return the low byte and change no pointer or hold.
- R11: Every output changes on the clock edge that samples the strobe, and each pulse lasts one cycle. Read data is driven with `rdata_oe` high for the one cycle after the sampling edge.
- R12: After synchronous reset all modes, number formats, load values and pulses are zero, every channel is unprogrammed, and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one cycle |
| wr_n | input | 1 | Write strobe, active low, one cycle |
| addr | input | 2 | Channel (0..2) or control-word port (3) |
| wdata | input | 8 | Write data byte |
| live_cnt | input | 48 | Current count of each channel, channel 0 in the low 16 bits |
| rdata | output | 8 | Read data byte |
| rdata_oe | output | 1 | High while `rdata` carries a read result |
| mode_o | output | 9 | 3-bit mode per channel |
| bcd_o | output | 3 | Decimal-count flag per channel |
| load_val_o | output | 48 | Assembled 16-bit load value per channel |
| load_pulse_o | output | 3 | Load value complete, one cycle per channel |
| first_pulse_o | output | 3 | First of two load bytes written, one cycle per channel |
| latch_req_o | output | 3 | Latch command accepted, one cycle per channel |

## Verification
The checks assume that bus strobes last exactly one cycle and are separated by at least one idle cycle. They also assume that the live count is steady across the sampling edge of any access. The host is assumed never to write a count while a two-byte read is half done. The random stimulus drives each access as a single strobe cycle followed by a return to idle, and it changes the live counts only between accesses. When the reference model shows a channel halfway through a byte-pair read, the stimulus turns a planned count write to that channel into a read. Reads at the control address, selects of the illegal channel, unprogrammed channels and repeated latch commands all occur on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_HI    = 2'b01,
    ACC_LO    = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;

  localparam logic [1:0] CTL_ADDR = 2'b11;
  localparam int MODE_W = 3;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [1:0]        ctl_sel,
  output logic [NUM_CH-1:0] ctl_we,
  output logic [NUM_CH-1:0] cnt_we,
  output logic [NUM_CH-1:0] cnt_re
);
  import tmr_pkg::*;

  logic wr_act, rd_act;

  always_comb begin
    wr_act = !cs_n && !wr_n && rd_n;
    rd_act = !cs_n && !rd_n && wr_n;
    for (int i = 0; i < NUM_CH; i++) begin
      cnt_we[i] = wr_act && (addr == 2'(i));
      cnt_re[i] = rd_act && (addr == 2'(i));
      ctl_we[i] = wr_act && (addr == CTL_ADDR) && (ctl_sel == 2'(i));
    end
  end

  // R1: a deselected bus reaches nothing
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (ctl_we == '0 && cnt_we == '0 && cnt_re == '0));

  // R2: the control-word port never takes a read
  a_r2_no_ctl_read: assert property (@(posedge clk) disable iff (rst)
    (addr == CTL_ADDR) |-> (cnt_re == '0));
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_we,
  input  logic                      cnt_we,
  input  logic                      cnt_re,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic [CNT_W-1:0]          live,
  output logic [tmr_pkg::MODE_W-1:0] mode,
  output logic                      bcd,
  output logic [CNT_W-1:0]          load_val,
  output logic                      load_pulse,
  output logic                      first_pulse,
  output logic                      latch_req,
  output logic [BYTE_W-1:0]         rd_byte
);
  import tmr_pkg::*;

  acc_e             acc;
  logic             wptr, rptr, held;
  logic [CNT_W-1:0] hold;
  logic [CNT_W-1:0] src;
  logic             is_latch;

  assign is_latch = (wdata[5:4] == 2'b00);

  always_comb begin
    src = held ? hold : live;
    case (acc)
      ACC_HI:   rd_byte = src[CNT_W-1:BYTE_W];
      ACC_PAIR: rd_byte = rptr ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      default:  rd_byte = src[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= ACC_LATCH;  mode <= '0;  bcd <= 1'b0;
      load_val <= '0;    hold <= '0;
      wptr <= 1'b0;      rptr <= 1'b0;  held <= 1'b0;
      load_pulse <= 1'b0; first_pulse <= 1'b0; latch_req <= 1'b0;
    end else begin
      load_pulse  <= 1'b0;
      first_pulse <= 1'b0;
      latch_req   <= 1'b0;
      if (ctl_we) begin
        if (is_latch) begin
          if (!held) begin
            hold      <= live;
            held      <= 1'b1;
            latch_req <= 1'b1;
          end
        end else begin
          acc  <= acc_e'(wdata[5:4]);
          mode <= wdata[3:1];
          bcd  <= wdata[0];
          wptr <= 1'b0;
          rptr <= 1'b0;
          held <= 1'b0;
        end
      end else if (cnt_we) begin
        case (acc)
          ACC_HI: begin
            load_val   <= {wdata, {BYTE_W{1'b0}}};
            load_pulse <= 1'b1;
          end
          ACC_LO: begin
            load_val   <= {{BYTE_W{1'b0}}, wdata};
            load_pulse <= 1'b1;
          end
          ACC_PAIR: begin
            if (wptr) begin
              load_val[CNT_W-1:BYTE_W] <= wdata;
              load_pulse <= 1'b1;
            end else begin
              load_val[BYTE_W-1:0] <= wdata;
              first_pulse <= 1'b1;
            end
            wptr <= !wptr;
          end
          default: ;
        endcase
      end else if (cnt_re) begin
        case (acc)
          ACC_HI, ACC_LO: held <= 1'b0;
          ACC_PAIR: begin
            if (rptr) held <= 1'b0;
            rptr <= !rptr;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a latch command leaves the channel settings untouched
  a_r8_latch_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && is_latch) |=> ($stable(mode) && $stable(bcd)));

  // R5: a completed load always follows a count write
  a_r5_load_after_write: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> $past(cnt_we));

  // R7: the first-byte strobe follows a count write and never joins a load strobe
  a_r7_first_after_write: assert property (@(posedge clk) disable iff (rst)
    first_pulse |-> ($past(cnt_we) && !load_pulse));

  // R9: a pending held value does not move
  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> $stable(hold));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        cnt_re,
  input  logic [NUM_CH*BYTE_W-1:0] rd_bytes,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     rdata_oe
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (cnt_re[i]) pick = rd_bytes[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= |cnt_re;
      if (|cnt_re) rdata <= pick;
    end
  end

  // R11: the data enable lasts one cycle and follows a counter read
  a_r11_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(|cnt_re));

  // R1: at most one channel is read at a time
  a_r1_single_read: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cnt_re));
endmodule

// File: rtl/timer_bus_ctrl.sv
module timer_bus_ctrl #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int MW    = tmr_pkg::MODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [1:0]              addr,
  input  logic [BYTE_W-1:0]       wdata,
  input  logic [NUM_CH*CNT_W-1:0] live_cnt,
  output logic [BYTE_W-1:0]       rdata,
  output logic                    rdata_oe,
  output logic [NUM_CH*MW-1:0]    mode_o,
  output logic [NUM_CH-1:0]       bcd_o,
  output logic [NUM_CH*CNT_W-1:0] load_val_o,
  output logic [NUM_CH-1:0]       load_pulse_o,
  output logic [NUM_CH-1:0]       first_pulse_o,
  output logic [NUM_CH-1:0]       latch_req_o
);
  logic [NUM_CH-1:0]        ctl_we, cnt_we, cnt_re;
  logic [NUM_CH*BYTE_W-1:0] rd_bytes;

  tmr_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .ctl_sel(wdata[BYTE_W-1:BYTE_W-2]),
    .ctl_we(ctl_we), .cnt_we(cnt_we), .cnt_re(cnt_re)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_chan_regs #(.BYTE_W(BYTE_W)) u_ch (
      .clk(clk), .rst(rst),
      .ctl_we(ctl_we[g]), .cnt_we(cnt_we[g]), .cnt_re(cnt_re[g]),
      .wdata(wdata), .live(live_cnt[g*CNT_W +: CNT_W]),
      .mode(mode_o[g*MW +: MW]), .bcd(bcd_o[g]),
      .load_val(load_val_o[g*CNT_W +: CNT_W]),
      .load_pulse(load_pulse_o[g]), .first_pulse(first_pulse_o[g]),
      .latch_req(latch_req_o[g]), .rd_byte(rd_bytes[g*BYTE_W +: BYTE_W])
    );
  end

  tmr_read_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_rmux (
    .clk(clk), .rst(rst), .cnt_re(cnt_re), .rd_bytes(rd_bytes),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // R11: the latch strobe and the load strobe of a channel never coincide
  a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    (latch_req_o & (load_pulse_o | first_pulse_o)) == '0);
endmodule

// File: tb/tb_timer_bus_ctrl.sv
module tb_timer_bus_ctrl;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic rdata_oe;
  logic [NCH*CW-1:0] live_cnt, load_val_o;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0] bcd_o, load_pulse_o, first_pulse_o, latch_req_o;

  timer_bus_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .live_cnt(live_cnt),
    .rdata(rdata), .rdata_oe(rdata_oe), .mode_o(mode_o), .bcd_o(bcd_o),
    .load_val_o(load_val_o), .load_pulse_o(load_pulse_o),
    .first_pulse_o(first_pulse_o), .latch_req_o(latch_req_o)
  );

  logic [15:0] live [NCH];
  always_comb for (int i = 0; i < NCH; i++) live_cnt[i*CW +: CW] = live[i];

  logic [1:0]  m_acc  [NCH];
  logic [2:0]  m_mode [NCH];
  logic        m_bcd  [NCH];
  logic        m_wptr [NCH];
  logic        m_rptr [NCH];
  logic        m_held [NCH];
  logic [15:0] m_hold [NCH];
  logic [15:0] m_load [NCH];
  logic [NCH-1:0] e_first, e_load, e_latch;
  logic e_oe;
  logic [7:0] e_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NCH*3-1:0] em;
    logic [NCH-1:0] eb;
    logic [NCH*CW-1:0] el;
    for (int i = 0; i < NCH; i++) begin
      em[i*3 +: 3] = m_mode[i];
      eb[i] = m_bcd[i];
      el[i*CW +: CW] = m_load[i];
    end
    chk(req, "mode", 48'(mode_o), 48'(em));
    chk(req, "bcd", 48'(bcd_o), 48'(eb));
    chk(req, "load", 48'(load_val_o), 48'(el));
    chk(req, "load_pulse", 48'(load_pulse_o), 48'(e_load));
    chk(req, "first_pulse", 48'(first_pulse_o), 48'(e_first));
    chk(req, "latch_req", 48'(latch_req_o), 48'(e_latch));
    chk(req, "rdata_oe", 48'(rdata_oe), 48'(e_oe));
    if (e_oe) chk(req, "rdata", 48'(rdata), 48'(e_rdata));
  endtask

  task automatic bus(input logic c, input logic r, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  function automatic void clr_exp();
    e_first = '0; e_load = '0; e_latch = '0; e_oe = 1'b0; e_rdata = '0;
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input string req);
    int ch;
    clr_exp();
    if (a == 2'd3) begin
      ch = int'(d[7:6]);
      if (ch < NCH) begin
        if (d[5:4] == 2'b00) begin
          if (!m_held[ch]) begin
            m_hold[ch] = live[ch]; m_held[ch] = 1'b1; e_latch[ch] = 1'b1;
          end
        end else begin
          m_acc[ch] = d[5:4]; m_mode[ch] = d[3:1]; m_bcd[ch] = d[0];
          m_wptr[ch] = 1'b0; m_rptr[ch] = 1'b0; m_held[ch] = 1'b0;
        end
      end
    end else begin
      ch = int'(a);
      case (m_acc[ch])
        2'b01: begin m_load[ch] = {d, 8'h00}; e_load[ch] = 1'b1; end
        2'b10: begin m_load[ch] = {8'h00, d}; e_load[ch] = 1'b1; end
        2'b11: begin
          if (m_wptr[ch]) begin m_load[ch][15:8] = d; e_load[ch] = 1'b1; end
          else begin m_load[ch][7:0] = d; e_first[ch] = 1'b1; end
          m_wptr[ch] = !m_wptr[ch];
        end
        default: ;
      endcase
    end
    bus(1'b0, 1'b1, 1'b0, a, d);
    check_all(req);
  endtask

  task automatic do_read(input logic [1:0] a, input string req);
    int ch;
    logic [15:0] s;
    clr_exp();
    if (a != 2'd3) begin
      ch = int'(a);
      s = m_held[ch] ? m_hold[ch] : live[ch];
      e_oe = 1'b1;
      case (m_acc[ch])
        2'b01: begin e_rdata = s[15:8]; m_held[ch] = 1'b0; end
        2'b10: begin e_rdata = s[7:0]; m_held[ch] = 1'b0; end
        2'b11: begin
          e_rdata = m_rptr[ch] ? s[15:8] : s[7:0];
          if (m_rptr[ch]) m_held[ch] = 1'b0;
          m_rptr[ch] = !m_rptr[ch];
        end
        default: e_rdata = s[7:0];
      endcase
    end
    bus(1'b0, 1'b0, 1'b1, a, 8'h00);
    check_all(req);
  endtask

  task automatic do_null(input int kind, input logic [1:0] a, input logic [7:0] d, input string req);
    clr_exp();
    case (kind)
      0: bus(1'b1, 1'b1, 1'b0, a, d);
      1: bus(1'b1, 1'b0, 1'b1, a, d);
      2: bus(1'b0, 1'b1, 1'b1, a, d);
      default: bus(1'b0, 1'b0, 1'b0, a, d);
    endcase
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0; rst = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      live[i] = 16'h0000; m_acc[i] = 2'b00; m_mode[i] = '0; m_bcd[i] = 1'b0;
      m_wptr[i] = 1'b0; m_rptr[i] = 1'b0; m_held[i] = 1'b0;
      m_hold[i] = '0; m_load[i] = '0;
    end
    clr_exp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R12");

    // R10: unprogrammed channel ignores count writes
    live[1] = 16'h5a3c;
    do_write(2'd1, 8'h77, "R10");
    do_read(2'd1, "R10");

    // R3 / R7: channel 0 two-byte, mode 2
    do_write(2'd3, 8'b00_11_010_0, "R3");
    do_write(2'd0, 8'h34, "R7");
    do_write(2'd0, 8'h12, "R7");
    // R5: channel 1 high byte only, decimal
    do_write(2'd3, 8'b01_01_101_1, "R5");
    do_write(2'd1, 8'hab, "R5");
    // R6: channel 2 low byte only
    do_write(2'd3, 8'b10_10_011_0, "R6");
    do_write(2'd2, 8'hcd, "R6");
    // R3: illegal channel selection ignored
    do_write(2'd3, 8'b11_11_111_1, "R3");
    // R2: reads at control address, or deselected
    do_read(2'd3, "R2");
    do_null(1, 2'd0, 8'h00, "R2");
    // R1: deselected write, idle, both strobes low
    do_null(0, 2'd1, 8'h99, "R1");
    do_null(2, 2'd2, 8'h99, "R1");
    do_null(3, 2'd0, 8'h99, "R1");

    // R8 / R9: latch channel 0, move live count, read held value
    live[0] = 16'ha5c3;
    do_write(2'd3, 8'b00_00_000_0, "R8");
    live[0] = 16'h1111;
    do_write(2'd3, 8'b00_00_111_1, "R8");
    do_read(2'd0, "R9");
    live[0] = 16'h2222;
    do_read(2'd0, "R9");
    do_read(2'd0, "R9");
    do_read(2'd0, "R9");
    // R5 / R6 reads
    live[1] = 16'hbeef; live[2] = 16'hcafe;
    do_read(2'd1, "R5");
    do_read(2'd2, "R6");
    // R4: control word resets pointers and drops a pending hold
    do_write(2'd0, 8'h55, "R7");
    live[0] = 16'h4321;
    do_write(2'd3, 8'b00_00_000_0, "R8");
    do_read(2'd0, "R9");
    do_write(2'd3, 8'b00_11_100_1, "R4");
    live[0] = 16'h8765;
    do_read(2'd0, "R4");
    do_write(2'd0, 8'h66, "R4");

    // random mix
    for (int i = 0; i < 800; i++) begin
      int op, ch;
      logic [7:0] d;
      for (int k = 0; k < NCH; k++) if ($urandom_range(0, 2) == 0) live[k] = 16'($urandom());
      op = $urandom_range(0, 10);
      ch = $urandom_range(0, NCH - 1);
      d  = 8'($urandom());
      if (op <= 2) begin
        d[5:4] = ($urandom_range(0, 3) == 0) ? 2'b00 : d[5:4];
        do_write(2'd3, d, "R3");
      end else if (op <= 5) begin
        if (m_acc[ch] == 2'b11 && m_rptr[ch]) do_read(2'(ch), "R9");
        else do_write(2'(ch), d, "R7");
      end else if (op <= 8) begin
        do_read(2'($urandom_range(0, 3)), "R9");
      end else begin
        do_null($urandom_range(0, 3), 2'($urandom_range(0, 3)), d, "R1");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule